// File: doc/BRIEF.md
# External Interrupt Trigger Selector

This block turns external interrupt pins into two flags per line. The status flag records that an active edge was seen, and only software clears it. The request flag is the one the processor polls. It clears when the processor vectors to the line's handler, or when software writes a clear. A per-line mode field picks the trigger from four choices: falling edge, rising edge, either edge, or bypass. In bypass, a second select bit picks between a falling edge and a sustained low level.

The number of lines, the length of low level that qualifies, and an optional resynchronizer depth are parameters. A change of trigger setup takes effect on the next clock. The stored pin history is reloaded at that clock, so that switching modes never produces a phantom event. A set that arrives together with a clear strobe always wins, so a software write that lands in the same cycle as a new event never hides that event.

Top module: `exti_trigger_sel`

## Requirements
- R1: After reset both flags of every line read 0, and the first clock after reset produces no event.
- R2: Mode field per line, 2 bits: 00 = falling edge, 01 = rising edge, 10 = either edge, 11 = bypass.
- R3: In modes 00, 01 and 10 a selected edge of the pin sets the status flag and the request flag together, visible after the clock that samples the new pin level. An edge of the other polarity has no effect.
- R4: In bypass with the level select at 0, a falling edge sets both flags. A rising edge, or a low level held for any length, sets neither.
- R5: In bypass with the level select at 1, the request flag is set once the pin has been sampled low on LOW_CYCLES (default 2) consecutive clocks. A single low sample does nothing, and the status flag is never set in this mode.
- R6: A low level qualifies only once per low period. After the request is acknowledged while the pin stays low, no new request appears until the pin has been high and then low again for the qualifying length.
- R7: In level mode, a status flag left set (for example by an earlier edge mode) blocks the level event, so no request is raised.
- R8: The vector acknowledge strobe and the software request clear strobe each clear only the request flag, and leave the status flag unchanged.
- R9: The software status clear strobe clears only the status flag, and leaves the request flag unchanged.
- R10: When a set and a clear of the same flag happen in one clock, the flag ends up set.
- R11: A change of mode or level select is applied at the next clock. That clock reloads the pin history and produces no event, even if the pin moved in the same cycle.
- R12: Each line is independent: activity on one line never changes the flags of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_CH | External interrupt pins, one per line |
| mode_i | input | 2*N_CH | Trigger mode per line, line k in bits [2k+1:2k] |
| byp_lvl_i | input | N_CH | Bypass select per line: 1 = low level, 0 = falling edge |
| sts_clr_i | input | N_CH | Software clear strobe for the status flag |
| req_clr_i | input | N_CH | Software clear strobe for the request flag |
| vec_ack_i | input | N_CH | Vector acknowledge, clears the request flag |
| sts_o | output | N_CH | Status flag per line |
| req_o | output | N_CH | Request flag per line |

## Verification
The assertions assume three things about the inputs:
- The pins are already synchronous to clk, as they are when SYNC_STAGES is 0.
- The clear and acknowledge strobes are sampled only at rising edges.
- The pin sample from one clock earlier is a meaningful history for the level check.

The stimulus drives every pin, mode and strobe change half a period away from the active edge. Each strobe is held for exactly one clock. Mode changes are made only with the pin at a known level, so that the expected outcome of the reload clock is fixed.

// File: rtl/exti_pkg.sv
package exti_pkg;

   typedef enum logic [1:0] {
      TRIG_FALL   = 2'b00,
      TRIG_RISE   = 2'b01,
      TRIG_BOTH   = 2'b10,
      TRIG_BYPASS = 2'b11
   } trig_mode_e;

   typedef struct packed {
      trig_mode_e mode;
      logic       lvl;
   } trig_cfg_t;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
   parameter int   STAGES  = 0,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0 || STAGES > 2) begin : g_bad_stages
      $error("exti_sync: STAGES must be 0, 1 or 2");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
         end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
               chain_q[k] <= chain_q[k-1];
            end
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/exti_detect.sv
module exti_detect
   import exti_pkg::*;
#(
   parameter int LOW_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  trig_cfg_t cfg_i,
   input  logic      block_lvl_i,
   output logic      edge_evt_o,
   output logic      lvl_evt_o,
   output logic      lvl_mode_o
);

   localparam int CW = $clog2(LOW_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(LOW_CYCLES - 1);
   localparam logic [CW-1:0] CNT_SAT  = CW'(LOW_CYCLES);

   if (LOW_CYCLES < 2) begin : g_bad_low
      $error("exti_detect: LOW_CYCLES must be at least 2");
   end

   trig_cfg_t       cfg_q;
   logic            hist_q;
   logic            hist_vld_q;
   logic [CW-1:0]   low_cnt_q;

   logic stale;
   logic fall;
   logic rise;
   logic edge_hit;
   logic low_hit;

   // history is untrusted right after reset or on any setup change
   assign stale = !hist_vld_q || (cfg_i != cfg_q);
   assign fall  = hist_q && !pin_i;
   assign rise  = !hist_q && pin_i;

   always_comb begin
      unique case (cfg_q.mode)
         TRIG_FALL:   edge_hit = fall;
         TRIG_RISE:   edge_hit = rise;
         TRIG_BOTH:   edge_hit = fall || rise;
         TRIG_BYPASS: edge_hit = !cfg_q.lvl && fall;
         default:     edge_hit = 1'b0;
      endcase
   end

   assign lvl_mode_o = (cfg_q.mode == TRIG_BYPASS) && cfg_q.lvl;
   assign low_hit    = !pin_i && (low_cnt_q == CNT_LAST);

   assign edge_evt_o = !stale && edge_hit;
   assign lvl_evt_o  = !stale && lvl_mode_o && low_hit && !block_lvl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '{mode: TRIG_FALL, lvl: 1'b0};
         hist_q     <= 1'b1;
         hist_vld_q <= 1'b0;
         low_cnt_q  <= '0;
      end else begin
         cfg_q      <= cfg_i;
         hist_q     <= pin_i;
         hist_vld_q <= 1'b1;
         if (stale || pin_i) begin
            low_cnt_q <= '0;
         end else if (low_cnt_q != CNT_SAT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
         end
      end
   end

   // R5: a level event needs the pin low now and on the clock before
   a_r5_low_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_evt_o |-> (!pin_i && !$past(pin_i)));

   // R6: one level event per low period, never two in a row
   a_r6_one_per_episode: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_evt_o |=> !lvl_evt_o);

endmodule

// File: rtl/exti_flag.sv
module exti_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign q_o = flag_q;

   // R10: a set in the same clock as a clear leaves the flag set
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

endmodule

// File: rtl/exti_trigger_sel.sv
module exti_trigger_sel
   import exti_pkg::*;
#(
   parameter int N_CH        = 2,
   parameter int LOW_CYCLES  = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   pin_i,
   input  logic [2*N_CH-1:0] mode_i,
   input  logic [N_CH-1:0]   byp_lvl_i,
   input  logic [N_CH-1:0]   sts_clr_i,
   input  logic [N_CH-1:0]   req_clr_i,
   input  logic [N_CH-1:0]   vec_ack_i,
   output logic [N_CH-1:0]   sts_o,
   output logic [N_CH-1:0]   req_o
);

   if (N_CH < 1) begin : g_bad_nch
      $error("exti_trigger_sel: N_CH must be at least 1");
   end

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_line
      logic      pin_s;
      trig_cfg_t cfg;
      logic      edge_evt;
      logic      lvl_evt;
      logic      lvl_mode;
      logic      sts_q;
      logic      req_q;

      assign cfg = '{mode: trig_mode_e'(mode_i[2*ch +: 2]), lvl: byp_lvl_i[ch]};

      exti_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[ch]),
         .q_o   (pin_s)
      );

      exti_detect #(.LOW_CYCLES(LOW_CYCLES)) u_detect (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_i       (pin_s),
         .cfg_i       (cfg),
         .block_lvl_i (sts_q),
         .edge_evt_o  (edge_evt),
         .lvl_evt_o   (lvl_evt),
         .lvl_mode_o  (lvl_mode)
      );

      exti_flag u_sts (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (edge_evt),
         .clr_i (sts_clr_i[ch]),
         .q_o   (sts_q)
      );

      exti_flag u_req (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (edge_evt || lvl_evt),
         .clr_i (vec_ack_i[ch] || req_clr_i[ch]),
         .q_o   (req_q)
      );

      assign sts_o[ch] = sts_q;
      assign req_o[ch] = req_q;

      // R3: the status flag never rises without the request flag
      a_r3_status_with_request: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_o[ch]) |-> req_o[ch]);

      // R5: the status flag is never raised while level mode is in force
      a_r5_level_no_status: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_o[ch]) |-> !$past(lvl_mode));

      // R8: an acknowledge leaves the status flag alone
      a_r8_ack_spares_status: assert property (@(posedge clk) disable iff (!rst_n)
         (vec_ack_i[ch] && !sts_clr_i[ch] && sts_o[ch]) |=> sts_o[ch]);

      // R9: a status clear leaves the request flag alone
      a_r9_stsclr_spares_request: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_clr_i[ch] && !vec_ack_i[ch] && !req_clr_i[ch] && req_o[ch]) |=> req_o[ch]);
   end

endmodule

// File: tb/exti_trigger_sel_bench.sv
`timescale 1ns/1ps
module exti_trigger_sel_bench;

   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0]   pin = '1;
   logic [2*N-1:0] mode = '0;
   logic [N-1:0]   byp_lvl = '0;
   logic [N-1:0]   sts_clr = '0;
   logic [N-1:0]   req_clr = '0;
   logic [N-1:0]   vec_ack = '0;
   logic [N-1:0]   sts;
   logic [N-1:0]   req;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   exti_trigger_sel #(.N_CH(N), .LOW_CYCLES(2), .SYNC_STAGES(0)) u_exti_trigger_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin),
      .mode_i    (mode),
      .byp_lvl_i (byp_lvl),
      .sts_clr_i (sts_clr),
      .req_clr_i (req_clr),
      .vec_ack_i (vec_ack),
      .sts_o     (sts),
      .req_o     (req)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic lvl);
      mode[1:0]  = m;
      byp_lvl[0] = lvl;
      tick();
   endtask

   task automatic clear_all();
      sts_clr[0] = 1'b1;
      vec_ack[0] = 1'b1;
      tick();
      sts_clr[0] = 1'b0;
      vec_ack[0] = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 status after reset", sts[0], 1'b0);
      chk("R1 request after reset", req[0], 1'b0);
   endtask

   task automatic t_falling();
      set_cfg(2'b00, 1'b0);
      pin[0] = 1'b0; tick();
      chk("R2/R3 falling sets status", sts[0], 1'b1);
      chk("R3 falling sets request", req[0], 1'b1);
      clear_all();
      pin[0] = 1'b1; tick();
      chk("R3 rising ignored in falling mode req", req[0], 1'b0);
      chk("R3 rising ignored in falling mode sts", sts[0], 1'b0);
   endtask

   task automatic t_rising();
      set_cfg(2'b01, 1'b0);
      pin[0] = 1'b0; tick();
      chk("R2 falling ignored in rising mode", req[0], 1'b0);
      pin[0] = 1'b1; tick();
      chk("R2 rising mode sets request", req[0], 1'b1);
      chk("R2 rising mode sets status", sts[0], 1'b1);
      clear_all();
   endtask

   task automatic t_both();
      set_cfg(2'b10, 1'b0);
      pin[0] = 1'b0; tick();
      chk("R2 both mode falling", req[0], 1'b1);
      clear_all();
      pin[0] = 1'b1; tick();
      chk("R2 both mode rising", req[0], 1'b1);
      chk("R2 both mode rising status", sts[0], 1'b1);
      clear_all();
   endtask

   task automatic t_bypass_edge();
      set_cfg(2'b11, 1'b0);
      pin[0] = 1'b0; tick();
      chk("R4 bypass falling status", sts[0], 1'b1);
      chk("R4 bypass falling request", req[0], 1'b1);
      clear_all();
      tick(); tick();
      chk("R4 held low no request", req[0], 1'b0);
      pin[0] = 1'b1; tick();
      chk("R4 rising ignored", req[0], 1'b0);
   endtask

   task automatic t_level();
      set_cfg(2'b11, 1'b1);
      pin[0] = 1'b0; tick();
      chk("R5 one low sample no request", req[0], 1'b0);
      tick();
      chk("R5 two low samples request", req[0], 1'b1);
      chk("R5 level never sets status", sts[0], 1'b0);
      vec_ack[0] = 1'b1; tick(); vec_ack[0] = 1'b0;
      chk("R6 ack clears level request", req[0], 1'b0);
      tick(); tick(); tick();
      chk("R6 no retrigger while low", req[0], 1'b0);
      pin[0] = 1'b1; tick();
      pin[0] = 1'b0; tick(); tick();
      chk("R6 rearmed after high", req[0], 1'b1);
      vec_ack[0] = 1'b1; tick(); vec_ack[0] = 1'b0;
      pin[0] = 1'b1; tick();
      pin[0] = 1'b0; tick();
      pin[0] = 1'b1; tick();
      chk("R5 one-cycle glitch ignored", req[0], 1'b0);
   endtask

   task automatic t_level_block();
      set_cfg(2'b00, 1'b0);
      pin[0] = 1'b0; tick();
      vec_ack[0] = 1'b1; tick(); vec_ack[0] = 1'b0;
      chk("R8 ack leaves status", sts[0], 1'b1);
      chk("R8 ack clears request", req[0], 1'b0);
      pin[0] = 1'b1; tick();
      set_cfg(2'b11, 1'b1);
      pin[0] = 1'b0; tick(); tick(); tick();
      chk("R7 status blocks level request", req[0], 1'b0);
      sts_clr[0] = 1'b1; tick(); sts_clr[0] = 1'b0;
      chk("R9 status cleared", sts[0], 1'b0);
      chk("R9 request untouched", req[0], 1'b0);
      pin[0] = 1'b1; tick();
   endtask

   task automatic t_clear_indep();
      set_cfg(2'b00, 1'b0);
      pin[0] = 1'b0; tick();
      sts_clr[0] = 1'b1; tick(); sts_clr[0] = 1'b0;
      chk("R9 status clear", sts[0], 1'b0);
      chk("R9 request kept", req[0], 1'b1);
      req_clr[0] = 1'b1; tick(); req_clr[0] = 1'b0;
      chk("R8 software request clear", req[0], 1'b0);
      pin[0] = 1'b1; tick();
   endtask

   task automatic t_set_wins();
      set_cfg(2'b00, 1'b0);
      pin[0] = 1'b0; sts_clr[0] = 1'b1; vec_ack[0] = 1'b1; tick();
      sts_clr[0] = 1'b0; vec_ack[0] = 1'b0;
      chk("R10 status set beats clear", sts[0], 1'b1);
      chk("R10 request set beats ack", req[0], 1'b1);
      clear_all();
      pin[0] = 1'b1; tick();
   endtask

   task automatic t_cfg_change();
      set_cfg(2'b00, 1'b0);
      pin[0] = 1'b0; tick();
      clear_all();
      mode[1:0] = 2'b01; pin[0] = 1'b1; tick();
      chk("R11 no event on mode change clock", req[0], 1'b0);
      tick();
      chk("R11 no late event", req[0], 1'b0);
      pin[0] = 1'b0; tick();
      chk("R11 new mode ignores falling", req[0], 1'b0);
      pin[0] = 1'b1; tick();
      chk("R11 new mode active", req[0], 1'b1);
      clear_all();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(); tick();
      t_reset();
      t_falling();
      t_rising();
      t_both();
      t_bypass_edge();
      t_level();
      t_level_block();
      t_clear_indep();
      t_set_wins();
      t_cfg_change();
      chk("R12 idle line status", sts[1], 1'b0);
      chk("R12 idle line request", req[1], 1'b0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule